// File: doc/BRIEF.md
# TIS Response Receive Sequencer

This block acts as a bus master that collects the reply of a trusted-platform module once a command has been started. A `start` pulse begins the sequence. The block then polls the status register until the device reports both valid status and available data. It drains the data FIFO register one byte per read. It never reads more bytes in one burst than the burst count the status word advertised. Each byte leaves on a byte stream together with its position in the reply. The stream has no back-pressure.

The first bytes form a header. When the sixth byte arrives, a four-byte length field is decoded from it. That length replaces the provisional byte budget, which until then is the caller's buffer limit. Lengths shorter than the header or longer than the buffer abort the run. After every burst the block re-reads status. The transfer ends when the budget is used up or when the device stops reporting data. Any data left behind is reported as an error. A clean end writes the command-ready value to the status register so the device returns to idle. A one-cycle `done` pulse carries the byte count and a result code.

Top module: `tis_rx_seq`

## Requirements
- R1: After an accepted start, the block reads status (address select 0) until bit 7 (valid) and bit 4 (data available) are both set. Failed reads are spaced by POLL_GAP idle cycles. After POLL_LIMIT consecutive failed reads it ends with code 1 (timeout), count 0 and no data read.
- R2: Each data read (address select 1) emits one byte with `byte_valid`, carrying the byte and its index 0, 1, 2 and so on. One burst never takes more reads than the burst count in status bits 23:8. The index never reaches the expected count, which starts at `buf_limit`.
- R3: When the byte with index 5 is read, the expected count becomes the 32-bit big-endian value held in bytes 2 to 5 (byte 2 most significant). A value equal to `buf_limit` is accepted.
- R4: A decoded length below 6 or above `buf_limit` ends the run with code 3 (bad size) and count 6. No further bus access is made.
- R5: A burst count of zero makes the block re-poll status. After POLL_LIMIT consecutive zero observations it ends with code 2 (stuck) and count 0. The first of these observations is the status value that ended the previous wait. Fewer zero observations than that are tolerated.
- R6: After each burst, status is read until bit 7 is set. POLL_LIMIT failed reads end the run with code 1 and the bytes read so far. The loop ends when the index count equals the expected count, or when data available drops, even if fewer bytes arrived than the header announced.
- R7: If data available is still set when the loop ends, the run ends with code 4 (bad message) and no command-ready write.
- R8: A clean end performs exactly one write, of 0x40 to status, and then pulses `done` with code 0 and the number of bytes read.
- R9: `busy` is high from the accepted start until `done`. A start pulse while busy is ignored.
- R10: After reset the block is idle, with no bus request, no `done` and no byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin draining a response |
| buf_limit | input | LEN_W | Largest reply the caller can accept |
| busy | output | 1 | Sequence in progress |
| bus_req | output | 1 | Bus access requested, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_fifo | output | 1 | 1 selects data FIFO, 0 selects status |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | One-cycle completion of the current access |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_index | output | LEN_W | Position of the byte in the reply |
| done | output | 1 | One-cycle end-of-run pulse |
| done_count | output | LEN_W | Bytes read in the run |
| done_err | output | 3 | 0 ok, 1 timeout, 2 stuck, 3 bad size, 4 bad message |

## Verification
The hardest conditions to reach from the ports are a device that reports data with a zero burst count long enough to exhaust the poll limit, and a device that holds more bytes than its own header announced. The bench device model has knobs for both. It can force a number of zero-burst status replies, hold bytes beyond the declared length, stop asserting valid after the first data read, or run out of bytes early. Counting its status and data reads shows that each abort happens at exactly the limit and with no stray bus traffic.

// File: rtl/tis_rx_pkg.sv
// Shared constants and types of the response receive sequencer.
// Assumes a 32-bit status word with the burst count in bits 23:8.
package tis_rx_pkg;

    localparam int STS_VALID_BIT = 7;
    localparam int STS_AVAIL_BIT = 4;
    localparam int BURST_LSB     = 8;
    localparam int BURST_W       = 16;
    localparam int HDR_BYTES     = 6;
    localparam logic [31:0] CMD_READY_WORD = 32'h0000_0040;

    typedef enum logic [2:0] {
        RX_OK       = 3'd0,
        RX_TIMEOUT  = 3'd1,
        RX_STUCK    = 3'd2,
        RX_BAD_SIZE = 3'd3,
        RX_BAD_MSG  = 3'd4
    } rx_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_DATA,
        ST_GAP,
        ST_BURST_CHK,
        ST_POLL_BURST,
        ST_READ,
        ST_WAIT_VALID,
        ST_WR_READY
    } rx_state_e;

endpackage

// File: rtl/tis_poll_pacer.sv
// Poll pacing for the receive sequencer.
// Counts consecutive unsatisfied observations and flags the one that reaches
// POLL_LIMIT; also times the idle gap between two status reads.
// Assumes the caller asserts clr whenever a wait is satisfied or restarted.
module tis_poll_pacer #(
    parameter int POLL_LIMIT = 16,
    parameter int POLL_GAP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic miss,
    input  logic gap_load,
    output logic last_miss,
    output logic gap_done
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);
    localparam int GAP_W = $clog2(POLL_GAP + 2);

    logic [CNT_W-1:0] miss_cnt;
    logic [GAP_W-1:0] gap_cnt;

    assign last_miss = miss && (miss_cnt == CNT_W'(POLL_LIMIT - 1));
    assign gap_done  = (gap_cnt == '0);

    // Consecutive-miss counter, restarted on success or when the limit is hit.
    always_ff @(posedge clk) begin
        if (!rst_n)                miss_cnt <= '0;
        else if (clr || last_miss) miss_cnt <= '0;
        else if (miss)             miss_cnt <= miss_cnt + 1'b1;
    end

    // Gap timer between polls.
    always_ff @(posedge clk) begin
        if (!rst_n)            gap_cnt <= '0;
        else if (gap_load)     gap_cnt <= GAP_W'(POLL_GAP);
        else if (gap_cnt != 0) gap_cnt <= gap_cnt - 1'b1;
    end

    // R5 / R1: the miss count never reaches the limit without an abort.
    p_miss_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt < CNT_W'(POLL_LIMIT));

endmodule

// File: rtl/tis_hdr_len.sv
// Header length capture.
// Keeps the last three received bytes so that, together with the byte being
// read now, a big-endian 32-bit length is available when header byte 5 lands.
// Also judges that length against the header size and the buffer limit.
// Assumes LEN_W <= 32.
module tis_hdr_len
    import tis_rx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic [7:0]       byte_in,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] len_out,
    output logic             len_bad
);
    logic [23:0] hist;
    logic [31:0] len_full;

    assign len_full = {hist, byte_in};
    assign len_out  = len_full[LEN_W-1:0];
    assign len_bad  = (len_full < 32'(HDR_BYTES)) || (len_full > 32'(limit));

    // Byte history shift register, oldest byte most significant.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) hist <= '0;
        else if (shift_en) hist <= {hist[15:0], byte_in};
    end

endmodule

// File: rtl/tis_rx_seq.sv
// Response receive sequencer (top).
// Drains a reply from the data FIFO register with paced status polling,
// burst-limited reads, header length decode and final command-ready write.
// Assumes a request/acknowledge bus: bus_req with its attributes stays stable
// until a one-cycle bus_ack that also carries read data.
module tis_rx_seq
    import tis_rx_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int POLL_LIMIT = 16,
    parameter int POLL_GAP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] buf_limit,
    output logic             busy,
    output logic             bus_req,
    output logic             bus_we,
    output logic             bus_fifo,
    output logic [31:0]      bus_wdata,
    input  logic [31:0]      bus_rdata,
    input  logic             bus_ack,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic [LEN_W-1:0] byte_index,
    output logic             done,
    output logic [LEN_W-1:0] done_count,
    output logic [2:0]       done_err
);
    rx_state_e          st, ret_st;
    logic [LEN_W-1:0]   off, exp_cnt, lim_q;
    logic [BURST_W-1:0] burst;

    logic               sts_valid, sts_avail, sts_both;
    logic [BURST_W-1:0] sts_burst;
    logic               more_bytes, sixth;
    logic               pace_clr, pace_miss, gap_load, last_miss, gap_done;
    logic               hdr_clr, hdr_shift, len_bad;
    logic [LEN_W-1:0]   len_dec;

    assign sts_valid  = bus_rdata[STS_VALID_BIT];
    assign sts_avail  = bus_rdata[STS_AVAIL_BIT];
    assign sts_both   = sts_valid && sts_avail;
    assign sts_burst  = bus_rdata[BURST_LSB +: BURST_W];
    assign more_bytes = (burst != '0) && (off < exp_cnt);
    assign sixth      = (off == LEN_W'(HDR_BYTES - 1));
    assign busy       = (st != ST_IDLE);

    // Bus request decode from the current state.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_fifo  = 1'b0;
        bus_wdata = '0;
        case (st)
            ST_WAIT_DATA, ST_POLL_BURST, ST_WAIT_VALID: bus_req = 1'b1;
            ST_READ: begin
                bus_req  = more_bytes;
                bus_fifo = 1'b1;
            end
            ST_WR_READY: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = CMD_READY_WORD;
            end
            default: ;
        endcase
    end

    // Poll bookkeeping: which observations satisfy or miss the current wait.
    always_comb begin
        pace_clr  = 1'b0;
        pace_miss = 1'b0;
        case (st)
            ST_IDLE:       pace_clr = start;
            ST_WAIT_DATA: begin
                pace_clr  = bus_ack && sts_both;
                pace_miss = bus_ack && !sts_both;
            end
            ST_BURST_CHK: begin
                pace_clr  = (burst != '0);
                pace_miss = (burst == '0);
            end
            ST_WAIT_VALID: begin
                pace_clr  = bus_ack && sts_valid;
                pace_miss = bus_ack && !sts_valid;
            end
            default: ;
        endcase
    end

    assign gap_load  = pace_miss && !last_miss;
    assign hdr_clr   = (st == ST_IDLE) && start;
    assign hdr_shift = (st == ST_READ) && bus_ack;

    tis_poll_pacer #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pace_clr),
        .miss      (pace_miss),
        .gap_load  (gap_load),
        .last_miss (last_miss),
        .gap_done  (gap_done)
    );

    tis_hdr_len #(.LEN_W(LEN_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hdr_clr),
        .shift_en (hdr_shift),
        .byte_in  (bus_rdata[7:0]),
        .limit    (lim_q),
        .len_out  (len_dec),
        .len_bad  (len_bad)
    );

    // Main sequence: state, counters, byte stream and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            ret_st     <= ST_IDLE;
            off        <= '0;
            exp_cnt    <= '0;
            lim_q      <= '0;
            burst      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_index <= '0;
            done       <= 1'b0;
            done_count <= '0;
            done_err   <= RX_OK;
        end else begin
            byte_valid <= 1'b0;
            done       <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    lim_q   <= buf_limit;
                    exp_cnt <= buf_limit;
                    off     <= '0;
                    burst   <= '0;
                    st      <= ST_WAIT_DATA;
                end
                ST_WAIT_DATA: if (bus_ack) begin
                    if (sts_both) begin
                        burst <= sts_burst;
                        st    <= ST_BURST_CHK;
                    end else if (last_miss) begin
                        done       <= 1'b1;
                        done_err   <= RX_TIMEOUT;
                        done_count <= off;
                        st         <= ST_IDLE;
                    end else begin
                        ret_st <= ST_WAIT_DATA;
                        st     <= ST_GAP;
                    end
                end
                ST_GAP: if (gap_done) st <= ret_st;
                ST_BURST_CHK: begin
                    if (burst != '0) begin
                        st <= ST_READ;
                    end else if (last_miss) begin
                        done       <= 1'b1;
                        done_err   <= RX_STUCK;
                        done_count <= off;
                        st         <= ST_IDLE;
                    end else begin
                        ret_st <= ST_POLL_BURST;
                        st     <= ST_GAP;
                    end
                end
                ST_POLL_BURST: if (bus_ack) begin
                    burst <= sts_burst;
                    st    <= ST_BURST_CHK;
                end
                ST_READ: begin
                    if (!more_bytes) begin
                        st <= ST_WAIT_VALID;
                    end else if (bus_ack) begin
                        byte_valid <= 1'b1;
                        byte_data  <= bus_rdata[7:0];
                        byte_index <= off;
                        off        <= off + 1'b1;
                        burst      <= burst - 1'b1;
                        if (sixth) begin
                            if (len_bad) begin
                                done       <= 1'b1;
                                done_err   <= RX_BAD_SIZE;
                                done_count <= off + 1'b1;
                                st         <= ST_IDLE;
                            end else begin
                                exp_cnt <= len_dec;
                            end
                        end
                    end
                end
                ST_WAIT_VALID: if (bus_ack) begin
                    if (sts_valid) begin
                        if ((off == exp_cnt) || !sts_avail) begin
                            if (sts_avail) begin
                                done       <= 1'b1;
                                done_err   <= RX_BAD_MSG;
                                done_count <= off;
                                st         <= ST_IDLE;
                            end else begin
                                st <= ST_WR_READY;
                            end
                        end else begin
                            burst <= sts_burst;
                            st    <= ST_BURST_CHK;
                        end
                    end else if (last_miss) begin
                        done       <= 1'b1;
                        done_err   <= RX_TIMEOUT;
                        done_count <= off;
                        st         <= ST_IDLE;
                    end else begin
                        ret_st <= ST_WAIT_VALID;
                        st     <= ST_GAP;
                    end
                end
                ST_WR_READY: if (bus_ack) begin
                    done       <= 1'b1;
                    done_err   <= RX_OK;
                    done_count <= off;
                    st         <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10: no bus traffic while idle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R2: a pending request is held until acknowledged.
    p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);

    // R2: no byte index at or beyond the caller's limit.
    p_index_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (byte_index < lim_q));

    // R8: the only write is command ready to status.
    p_ready_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (!bus_fifo && bus_wdata == CMD_READY_WORD));

    // R8: a clean finish follows an acknowledged write.
    p_ok_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err == RX_OK) |-> $past(bus_ack && bus_we));

    // R4: a size abort always reports the full header.
    p_badsize_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err == RX_BAD_SIZE) |-> (done_count == LEN_W'(HDR_BYTES)));

    // R9: completion is a single-cycle pulse.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_tis_rx_seq.sv
// Scoreboard bench for tis_rx_seq with a behavioural device model.
module sim_tis_rx_seq;
    localparam int LEN_W = 16;
    localparam int PLIM  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] buf_limit = '0;
    logic             busy, bus_req, bus_we, bus_fifo;
    logic [31:0]      bus_wdata;
    logic [31:0]      bus_rdata = '0;
    logic             bus_ack = 1'b0;
    logic             byte_valid, done;
    logic [7:0]       byte_data;
    logic [LEN_W-1:0] byte_index, done_count;
    logic [2:0]       done_err;

    always #10 clk = ~clk;

    tis_rx_seq #(.LEN_W(LEN_W), .POLL_LIMIT(PLIM), .POLL_GAP(3)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_limit(buf_limit),
        .busy(busy), .bus_req(bus_req), .bus_we(bus_we), .bus_fifo(bus_fifo),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_index(byte_index),
        .done(done), .done_count(done_count), .done_err(done_err)
    );

    int tests = 0, fails = 0, cyc = 0;

    // Device model state and counters.
    logic [7:0] mem [0:63];
    int m_len, m_bmax, m_inv, m_zero, m_kill, kill;
    int ptr, n_sts, n_data, n_wr, burst_given, since_sts, burst_viol;
    logic [31:0] last_w;

    typedef struct { logic [7:0] d; int idx; } exp_t;
    exp_t q [$];

    // Device model: answers each request one cycle later.
    always @(posedge clk) begin
        bus_ack <= 1'b0;
        if (rst_n && bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                n_wr = n_wr + 1;
                last_w = bus_wdata;
            end else if (bus_fifo) begin
                bus_rdata <= {24'h0, mem[ptr]};
                ptr = ptr + 1;
                n_data = n_data + 1;
                since_sts = since_sts + 1;
                if (since_sts > burst_given) burst_viol = burst_viol + 1;
                if (m_kill != 0) kill = 1;
            end else begin
                int b;
                n_sts = n_sts + 1;
                since_sts = 0;
                if (m_inv > 0) begin
                    m_inv = m_inv - 1;
                    bus_rdata <= 32'h0;
                    burst_given = 0;
                end else if (kill != 0) begin
                    bus_rdata <= 32'h0;
                    burst_given = 0;
                end else begin
                    b = (m_len - ptr < m_bmax) ? (m_len - ptr) : m_bmax;
                    if (m_zero > 0) begin
                        m_zero = m_zero - 1;
                        b = 0;
                    end
                    burst_given = b;
                    bus_rdata <= {8'h0, b[15:0], (ptr < m_len) ? 8'h90 : 8'h80};
                end
            end
        end
    end

    // Monitor: pop the scoreboard on every emitted byte.
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            exp_t e;
            tests++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected byte: got %02h idx %0d, expected none",
                         byte_data, byte_index);
            end else begin
                e = q.pop_front();
                if (byte_data !== e.d || int'(byte_index) != e.idx) begin
                    fails++;
                    $display("FAIL R2 byte: got %02h idx %0d, expected %02h idx %0d",
                             byte_data, byte_index, e.d, e.idx);
                end
            end
        end
    end

    // Global watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles, expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int want);
        tests++;
        if (got != want) begin
            fails++;
            $display("FAIL %s: got %0d, expected %0d", req, got, want);
        end
    endtask

    // Load a reply: header with big-endian length, then filler bytes.
    task automatic setup(input int len_field, input int dev_len, input int bmax);
        mem[0] = 8'hC4;
        mem[1] = 8'h00;
        mem[2] = len_field[31:24];
        mem[3] = len_field[23:16];
        mem[4] = len_field[15:8];
        mem[5] = len_field[7:0];
        for (int i = 6; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        m_len = dev_len; m_bmax = bmax;
        m_inv = 0; m_zero = 0; m_kill = 0; kill = 0;
        ptr = 0; n_sts = 0; n_data = 0; n_wr = 0; last_w = '0;
        burst_given = 0; since_sts = 0; burst_viol = 0;
    endtask

    // Driver: push the bytes the requirements predict.
    task automatic expect_bytes(input int n);
        for (int i = 0; i < n; i++) q.push_back('{d: mem[i], idx: i});
    endtask

    task automatic run(input string req, input int limit, input int e_err,
                       input int e_cnt, input int e_wr, input int poke);
        int c = 0;
        @(negedge clk);
        start = 1'b1;
        buf_limit = LEN_W'(limit);
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", int'(busy), 1);
        while (!done && c < 5000) begin
            @(negedge clk);
            c++;
            if (poke != 0 && c == poke) begin
                start = 1'b1;
                buf_limit = LEN_W'(2);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog: got no done, expected done", req);
        end
        check({req, " code"}, int'(done_err), e_err);
        check({req, " count"}, int'(done_count), e_cnt);
        check({req, " writes"}, n_wr, e_wr);
        if (e_wr != 0) check({req, " R8 write value"}, int'(last_w), 32'h40);
        check({req, " R2 burst pacing"}, burst_viol, 0);
        @(negedge clk);
        check({req, " R2 scoreboard empty"}, q.size(), 0);
        check({req, " R9 idle after done"}, int'(busy), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        setup(10, 10, 4);
        repeat (3) @(negedge clk);
        check("R10 busy", int'(busy), 0);
        check("R10 req", int'(bus_req), 0);
        check("R10 done", int'(done), 0);
        check("R10 byte strobe", int'(byte_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 / R3: normal reply, several bursts.
        setup(10, 10, 4); expect_bytes(10);
        run("R8", 32, 0, 10, 1, 0);
        check("R3 data reads", n_data, 10);

        // R1: invalid status before data appears.
        setup(7, 7, 64); m_inv = 3; expect_bytes(7);
        run("R1", 32, 0, 7, 1, 0);

        // R1: data never appears.
        setup(10, 0, 4);
        run("R1 timeout", 32, 1, 0, 0, 0);
        check("R1 status reads", n_sts, PLIM);
        check("R1 no data reads", n_data, 0);

        // R4: length above limit.
        setup(40, 50, 8); expect_bytes(6);
        run("R4 large", 32, 3, 6, 0, 0);
        check("R4 no extra reads", n_data, 6);

        // R4: length below header size.
        setup(5, 10, 8); expect_bytes(6);
        run("R4 small", 32, 3, 6, 0, 0);

        // R3: length equal to limit accepted.
        setup(32, 32, 8); expect_bytes(32);
        run("R3 equal", 32, 0, 32, 1, 0);

        // R5: permanent zero burst.
        setup(10, 10, 4); m_zero = 1000;
        run("R5 stuck", 32, 2, 0, 0, 0);
        check("R5 status reads", n_sts, PLIM);

        // R5: a few zero bursts are tolerated.
        setup(10, 10, 4); m_zero = 5; expect_bytes(10);
        run("R5 recover", 32, 0, 10, 1, 0);

        // R7: device holds more data than declared.
        setup(10, 12, 4); expect_bytes(10);
        run("R7", 32, 4, 10, 0, 0);

        // R2: limit below header size stops early.
        setup(10, 10, 4); expect_bytes(4);
        run("R2 small limit", 4, 4, 4, 0, 0);

        // R2: one byte per burst.
        setup(6, 6, 1); expect_bytes(6);
        run("R2 single", 6, 0, 6, 1, 0);

        // R6: data available drops before the declared length.
        setup(10, 8, 3); expect_bytes(8);
        run("R6 early end", 32, 0, 8, 1, 0);

        // R6: valid never returns after the first burst.
        setup(10, 10, 4); m_kill = 1; expect_bytes(4);
        run("R6 timeout", 32, 1, 4, 0, 0);

        // R9: a second start while busy is ignored.
        setup(12, 12, 2); expect_bytes(12);
        run("R9 restart", 32, 0, 12, 1, 15);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule